// File: doc/BRIEF.md
# Lockable Countdown Watchdog

This block is a down-counting watchdog advanced by a slow tick enable (nominally 32.768 kHz) that runs alongside the fast system clock. Software programs a reload value, a reload-enable mask and a configuration word, then fires a start strobe. From then on, an external reload-grant pulse must arrive before the counter runs out. If it does not, the block raises a timeout event and then requests a system reset.

While the watchdog runs, its setup is frozen. It can be halted only through a keyed sequence, and only if halting was allowed in the configuration before start. Counting can be paused while the CPU sleeps or while a debugger holds it. Each of these pauses is chosen by its own configuration bit. When the timeout interrupt is enabled, the reset request is held back by two ticks so that an interrupt handler can run first. The handler cannot cancel the reset, except by stopping the watchdog.

Register access is a single-cycle write port with a combinational read port. Both use 4-bit word addresses: 0 start, 1 stop, 2 timeout flag, 3 stopped flag, 4 interrupt-mask set, 5 interrupt-mask clear, 6 run status, 7 reload value, 8 reload-enable mask, 9 configuration, 10 stop key.

Top module: `lock_wdog`

## Requirements
- R1: A write with bit 0 set to address 0 starts the watchdog when it is idle. The start loads the counter from the reload value and sets the run status (address 6, bit 0, also the running output). A start written while the watchdog is already running has no effect on the count.
- R2: While running, each unpaused tick lowers the counter by one. The timeout flag sets on the tick that finds the counter at zero, which is exactly (reload value + 1) ticks after start.
- R3: A reload-grant pulse while running reloads the counter from the reload value, so the timeout comes (reload value + 1) ticks after the grant.
- R4: After reset, the reload value reads 0xFFFFFFFF, the reload-enable mask (address 8) reads 0x1, and the configuration reads 0x1. A written reload value below 0xF is stored as 0xF.
- R5: While running, writes to addresses 7, 8 and 9 are ignored. They are accepted again after a successful stop or after reset.
- R6: Configuration bit 0 keeps counting during CPU sleep; when it is 0, counting pauses while the sleep input is high. Bit 3 does the same for the debug-halt input. Bit 6 allows stopping. All other bits read 0.
- R7: A write with bit 0 set to address 1 stops the watchdog only when three conditions hold: it is running, configuration bit 6 was 1 at start, and the stop key is armed. The key is armed by writing exactly 0x6E524635 to address 10, and any other value written there disarms it. A successful stop clears the run status and sets the stopped flag.
- R8: A timeout always leads to a reset request. With interrupt-mask bit 0 clear, the reset output rises together with the timeout flag. With bit 0 set, it rises on the second tick after the timeout.
- R9: Once a timeout has happened, the reset output (or the pending reset) is withdrawn only by a successful stop. Clearing the flag or waiting does not withdraw it.
- R10: A write to address 4 sets the interrupt-mask bits that are 1 in the data, and a write to address 5 clears them. Bit 0 is timeout and bit 1 is stopped. Both addresses read back the mask. The interrupt output is high when any flag with its mask bit set is 1.
- R11: Event flags read 1 in bit 0 of addresses 2 and 3 once set. Any write to the flag's address clears it, unless the event recurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle slow-tick enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| reload_grant_i | input | 1 | Reload grant pulse |
| cpu_sleep_i | input | 1 | CPU is sleeping |
| dbg_halt_i | input | 1 | CPU is halted by the debugger |
| ev_timeout_o | output | 1 | Timeout flag |
| ev_stopped_o | output | 1 | Stopped flag |
| irq_o | output | 1 | Interrupt line |
| wdog_reset_o | output | 1 | Reset request |
| running_o | output | 1 | Watchdog is running |

## Verification
The bench checks the exact tick on which the timeout lands, both after start and after a reload grant. An off-by-one counter would fire a tick early or late. It also checks that a second start during a run does not restart the count, so a design that reloads on every start would time out late. The keyed stop is tried with a wrong key, with stopping disallowed, and with the correct sequence; a design that armed on any write or ignored the stop-allowed bit would halt when it should not. It checks the two-tick reset delay, a reset that survives clearing of the flag, and a pending reset cancelled by a stop. A design that reset early, late, or forgot the pending request would show a wrong reset output at one of those points.

// File: rtl/lock_wdog_pkg.sv
package lock_wdog_pkg;
    localparam int BUS_W = 32;
    localparam int ADR_W = 4;

    localparam logic [ADR_W-1:0] A_START   = 4'd0;
    localparam logic [ADR_W-1:0] A_STOP    = 4'd1;
    localparam logic [ADR_W-1:0] A_EV_TMO  = 4'd2;
    localparam logic [ADR_W-1:0] A_EV_STP  = 4'd3;
    localparam logic [ADR_W-1:0] A_IEN_SET = 4'd4;
    localparam logic [ADR_W-1:0] A_IEN_CLR = 4'd5;
    localparam logic [ADR_W-1:0] A_RUN     = 4'd6;
    localparam logic [ADR_W-1:0] A_RELOAD  = 4'd7;
    localparam logic [ADR_W-1:0] A_RQEN    = 4'd8;
    localparam logic [ADR_W-1:0] A_CFG     = 4'd9;
    localparam logic [ADR_W-1:0] A_KEY     = 4'd10;

    localparam logic [BUS_W-1:0] STOP_KEY = 32'h6E52_4635;

    localparam int CFG_SLEEP_BIT  = 0;
    localparam int CFG_HALT_BIT   = 3;
    localparam int CFG_STOPEN_BIT = 6;

    typedef struct packed {
        logic stop_en;
        logic halt_run;
        logic sleep_run;
    } cfg_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import lock_wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RQ_W       = 8,
    parameter int RELOAD_MIN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             running_i,
    input  logic             tmo_set_i,
    input  logic             stp_set_i,
    output logic             start_o,
    output logic             stop_ok_o,
    output logic [CNT_W-1:0] reload_o,
    output cfg_t             cfg_o,
    output logic [1:0]       ien_o,
    output logic             ev_tmo_o,
    output logic             ev_stp_o,
    output logic [BUS_W-1:0] rdata_o
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(RELOAD_MIN);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [RQ_W-1:0]  rqen;
        cfg_t             cfg;
        logic [1:0]       ien;
        logic             armed;
        logic             ev_tmo;
        logic             ev_stp;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] wval;

    always_comb begin
        st_d      = st_q;
        wval      = wdata[CNT_W-1:0];
        start_o   = wr_en && (addr == A_START) && wdata[0] && !running_i;
        stop_ok_o = wr_en && (addr == A_STOP) && wdata[0] && running_i
                    && st_q.cfg.stop_en && st_q.armed;

        if (wr_en && !running_i) begin
            if (addr == A_RELOAD) st_d.reload = (wval < MIN_V) ? MIN_V : wval;
            if (addr == A_RQEN)   st_d.rqen   = wdata[RQ_W-1:0];
            if (addr == A_CFG) begin
                st_d.cfg.sleep_run = wdata[CFG_SLEEP_BIT];
                st_d.cfg.halt_run  = wdata[CFG_HALT_BIT];
                st_d.cfg.stop_en   = wdata[CFG_STOPEN_BIT];
            end
        end
        if (wr_en && addr == A_KEY)     st_d.armed = (wdata == STOP_KEY);
        if (wr_en && addr == A_IEN_SET) st_d.ien   = st_q.ien | wdata[1:0];
        if (wr_en && addr == A_IEN_CLR) st_d.ien   = st_q.ien & ~wdata[1:0];
        if (wr_en && addr == A_EV_TMO)  st_d.ev_tmo = 1'b0;
        if (wr_en && addr == A_EV_STP)  st_d.ev_stp = 1'b0;
        if (tmo_set_i) st_d.ev_tmo = 1'b1;
        if (stp_set_i) st_d.ev_stp = 1'b1;

        rdata_o = '0;
        case (addr)
            A_EV_TMO:  rdata_o[0] = st_q.ev_tmo;
            A_EV_STP:  rdata_o[0] = st_q.ev_stp;
            A_IEN_SET,
            A_IEN_CLR: rdata_o[1:0] = st_q.ien;
            A_RUN:     rdata_o[0] = running_i;
            A_RELOAD:  rdata_o = BUS_W'(st_q.reload);
            A_RQEN:    rdata_o = BUS_W'(st_q.rqen);
            A_CFG: begin
                rdata_o[CFG_SLEEP_BIT]  = st_q.cfg.sleep_run;
                rdata_o[CFG_HALT_BIT]   = st_q.cfg.halt_run;
                rdata_o[CFG_STOPEN_BIT] = st_q.cfg.stop_en;
            end
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload        <= '1;
            st_q.rqen          <= RQ_W'(1);
            st_q.cfg.sleep_run <= 1'b1;
            st_q.cfg.halt_run  <= 1'b0;
            st_q.cfg.stop_en   <= 1'b0;
            st_q.ien           <= '0;
            st_q.armed         <= 1'b0;
            st_q.ev_tmo        <= 1'b0;
            st_q.ev_stp        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;
    assign cfg_o    = st_q.cfg;
    assign ien_o    = st_q.ien;
    assign ev_tmo_o = st_q.ev_tmo;
    assign ev_stp_o = st_q.ev_stp;
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             grant_i,
    input  logic             sleep_i,
    input  logic             halt_i,
    input  logic             sleep_run_i,
    input  logic             halt_run_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             running_o,
    output logic             timeout_o
);
    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic count_en;

    always_comb begin
        st_d     = st_q;
        count_en = tick_i && st_q.running
                   && !(sleep_i && !sleep_run_i)
                   && !(halt_i && !halt_run_i);
        timeout_o = count_en && !grant_i && !stop_i && (st_q.cnt == '0);

        if (start_i) begin
            st_d.running = 1'b1;
            st_d.cnt     = reload_i;
        end else if (stop_i) begin
            st_d.running = 1'b0;
        end else if (st_q.running && grant_i) begin
            st_d.cnt = reload_i;
        end else if (count_en) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.running <= 1'b0;
            st_q.cnt     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o = st_q.running;
endmodule

// File: rtl/wdg_rstctl.sv
module wdg_rstctl #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic timeout_i,
    input  logic irq_en_i,
    input  logic cancel_i,
    output logic req_o
);
    localparam int DW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] dly;
        logic          req;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cancel_i) begin
            st_d = '0;
        end else if (timeout_i) begin
            if (irq_en_i && DELAY > 0) begin
                st_d.pend = 1'b1;
                st_d.dly  = DW'(DELAY);
            end else begin
                st_d.req = 1'b1;
            end
        end else if (st_q.pend && tick_i) begin
            if (st_q.dly <= DW'(1)) begin
                st_d.pend = 1'b0;
                st_d.dly  = '0;
                st_d.req  = 1'b1;
            end else begin
                st_d.dly = st_q.dly - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/lock_wdog.sv
module lock_wdog
    import lock_wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RQ_W       = 8,
    parameter int RELOAD_MIN = 15,
    parameter int RST_DELAY  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        bus_wr_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    input  logic        reload_grant_i,
    input  logic        cpu_sleep_i,
    input  logic        dbg_halt_i,
    output logic        ev_timeout_o,
    output logic        ev_stopped_o,
    output logic        irq_o,
    output logic        wdog_reset_o,
    output logic        running_o
);
    logic             start_w, stop_ok_w, running_w, timeout_w;
    logic [CNT_W-1:0] reload_w;
    cfg_t             cfg_w;
    logic [1:0]       ien_w;
    logic             ev_tmo_w, ev_stp_w;

    wdg_regs #(.CNT_W(CNT_W), .RQ_W(RQ_W), .RELOAD_MIN(RELOAD_MIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_i),
        .addr      (bus_addr_i),
        .wdata     (bus_wdata_i),
        .running_i (running_w),
        .tmo_set_i (timeout_w),
        .stp_set_i (stop_ok_w),
        .start_o   (start_w),
        .stop_ok_o (stop_ok_w),
        .reload_o  (reload_w),
        .cfg_o     (cfg_w),
        .ien_o     (ien_w),
        .ev_tmo_o  (ev_tmo_w),
        .ev_stp_o  (ev_stp_w),
        .rdata_o   (bus_rdata_o)
    );

    wdg_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .start_i     (start_w),
        .stop_i      (stop_ok_w),
        .grant_i     (reload_grant_i),
        .sleep_i     (cpu_sleep_i),
        .halt_i      (dbg_halt_i),
        .sleep_run_i (cfg_w.sleep_run),
        .halt_run_i  (cfg_w.halt_run),
        .reload_i    (reload_w),
        .running_o   (running_w),
        .timeout_o   (timeout_w)
    );

    wdg_rstctl #(.DELAY(RST_DELAY)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .timeout_i (timeout_w),
        .irq_en_i  (ien_w[0]),
        .cancel_i  (stop_ok_w),
        .req_o     (wdog_reset_o)
    );

    assign irq_o        = (ev_tmo_w & ien_w[0]) | (ev_stp_w & ien_w[1]);
    assign ev_timeout_o = ev_tmo_w;
    assign ev_stopped_o = ev_stp_w;
    assign running_o    = running_w;
endmodule

// File: rtl/lock_wdog_chk.sv
module lock_wdog_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             start,
    input logic             stop_ok,
    input logic [2:0]       cfg,
    input logic [CNT_W-1:0] reload,
    input logic             ev_tmo,
    input logic             ev_stp,
    input logic             ien0,
    input logic             reset_req
);
    // R1
    run_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(start));

    // R5
    setup_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ($stable(cfg) && $stable(reload)));

    // R7
    stop_flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_stp) |-> !running);

    // R8
    held_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ev_tmo) && $past(ien0) && !$past(reset_req)) |-> !reset_req);

    // R8
    direct_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ev_tmo) && !$past(ien0)) |-> reset_req);

    // R9
    reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_req) |-> $past(stop_ok));
endmodule

bind lock_wdog lock_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running_w),
    .start     (start_w),
    .stop_ok   (stop_ok_w),
    .cfg       (cfg_w),
    .reload    (reload_w),
    .ev_tmo    (ev_tmo_w),
    .ev_stp    (ev_stp_w),
    .ien0      (ien_w[0]),
    .reset_req (wdog_reset_o)
);

// File: tb/lock_wdog_tb.sv
module lock_wdog_tb;
    import lock_wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        grant = 1'b0;
    logic        sleep = 1'b0;
    logic        halt = 1'b0;
    logic        ev_tmo, ev_stp, irq, wreset, running;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    lock_wdog u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .reload_grant_i(grant), .cpu_sleep_i(sleep), .dbg_halt_i(halt),
        .ev_timeout_o(ev_tmo), .ev_stopped_o(ev_stp), .irq_o(irq),
        .wdog_reset_o(wreset), .running_o(running)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_grant();
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic keyed_stop();
        wr_reg(A_KEY, STOP_KEY);
        wr_reg(A_STOP, 32'h1);
    endtask

    task automatic clear_flags();
        wr_reg(A_EV_TMO, 32'h0);
        wr_reg(A_EV_STP, 32'h0);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd_reg(A_RELOAD, v); check("R4 reload reset", v, 32'hFFFF_FFFF);
        rd_reg(A_RQEN, v);   check("R4 reload-enable reset", v, 32'h1);
        rd_reg(A_CFG, v);    check("R4 config reset", v, 32'h1);
        rd_reg(A_RUN, v);    check("R1 idle after reset", v, 32'h0);
        check("R8 no reset request at reset", {31'b0, wreset}, 32'h0);
        check("R10 irq low at reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_setup_regs();
        logic [31:0] v;
        wr_reg(A_RELOAD, 32'd3);
        rd_reg(A_RELOAD, v); check("R4 reload clamped to minimum", v, 32'hF);
        wr_reg(A_RELOAD, 32'd20);
        rd_reg(A_RELOAD, v); check("R4 reload written", v, 32'd20);
        wr_reg(A_CFG, 32'hFF);
        rd_reg(A_CFG, v);    check("R6 config keeps bits 0,3,6", v, 32'h49);
    endtask

    task automatic t_period();
        wr_reg(A_CFG, 32'h41);
        wr_reg(A_RELOAD, 32'd20);
        wr_reg(A_START, 32'h1);
        check("R1 running after start", {31'b0, running}, 32'h1);
        ticks(20);
        check("R2 no timeout after reload ticks", {31'b0, ev_tmo}, 32'h0);
        ticks(1);
        check("R2 timeout at reload+1 ticks", {31'b0, ev_tmo}, 32'h1);
        check("R8 immediate reset when irq masked", {31'b0, wreset}, 32'h1);
        keyed_stop();
        check("R7 stop clears running", {31'b0, running}, 32'h0);
        check("R7 stopped flag set", {31'b0, ev_stp}, 32'h1);
        check("R9 stop withdraws reset", {31'b0, wreset}, 32'h0);
        clear_flags();
        check("R11 timeout flag cleared by write", {31'b0, ev_tmo}, 32'h0);
        check("R11 stopped flag cleared by write", {31'b0, ev_stp}, 32'h0);
    endtask

    task automatic t_lock_and_keys();
        logic [31:0] v;
        wr_reg(A_START, 32'h1);
        wr_reg(A_RELOAD, 32'd30);
        rd_reg(A_RELOAD, v); check("R5 reload locked while running", v, 32'd20);
        wr_reg(A_CFG, 32'h0);
        rd_reg(A_CFG, v);    check("R5 config locked while running", v, 32'h41);
        wr_reg(A_RQEN, 32'hF0);
        rd_reg(A_RQEN, v);   check("R5 reload-enable locked while running", v, 32'h1);
        ticks(10);
        wr_reg(A_START, 32'h1);
        ticks(10);
        check("R1 second start did not restart: no early timeout", {31'b0, ev_tmo}, 32'h0);
        ticks(1);
        check("R1 second start did not restart: timeout on time", {31'b0, ev_tmo}, 32'h1);
        wr_reg(A_KEY, 32'h1234_5678);
        wr_reg(A_STOP, 32'h1);
        check("R7 wrong key refuses stop", {31'b0, running}, 32'h1);
        check("R9 reset kept after refused stop", {31'b0, wreset}, 32'h1);
        keyed_stop();
        check("R7 right key stops", {31'b0, running}, 32'h0);
        wr_reg(A_RELOAD, 32'd30);
        rd_reg(A_RELOAD, v); check("R5 reload writable after stop", v, 32'd30);
        wr_reg(A_RELOAD, 32'd20);
        clear_flags();
    endtask

    task automatic t_grant();
        wr_reg(A_START, 32'h1);
        ticks(15);
        pulse_grant();
        ticks(20);
        check("R3 no timeout before reload+1 ticks after grant", {31'b0, ev_tmo}, 32'h0);
        ticks(1);
        check("R3 timeout reload+1 ticks after grant", {31'b0, ev_tmo}, 32'h1);
        keyed_stop();
        clear_flags();
    endtask

    task automatic t_pause();
        wr_reg(A_CFG, 32'h40);
        wr_reg(A_START, 32'h1);
        sleep = 1'b1;
        ticks(30);
        sleep = 1'b0;
        check("R6 sleep pauses count", {31'b0, ev_tmo}, 32'h0);
        halt = 1'b1;
        ticks(30);
        halt = 1'b0;
        check("R6 debug halt pauses count", {31'b0, ev_tmo}, 32'h0);
        ticks(20);
        check("R6 resumed count not yet expired", {31'b0, ev_tmo}, 32'h0);
        ticks(1);
        check("R6 resumed count expires on time", {31'b0, ev_tmo}, 32'h1);
        keyed_stop();
        clear_flags();
        wr_reg(A_CFG, 32'h49);
        wr_reg(A_START, 32'h1);
        sleep = 1'b1; halt = 1'b1;
        ticks(21);
        sleep = 1'b0; halt = 1'b0;
        check("R6 run bits keep counting in sleep and halt", {31'b0, ev_tmo}, 32'h1);
        keyed_stop();
        clear_flags();
    endtask

    task automatic t_delay_irq();
        logic [31:0] v;
        wr_reg(A_RELOAD, 32'd15);
        wr_reg(A_IEN_SET, 32'h1);
        rd_reg(A_IEN_SET, v); check("R10 mask read at set address", v, 32'h1);
        wr_reg(A_START, 32'h1);
        ticks(16);
        check("R2 timeout at 16 ticks for reload 15", {31'b0, ev_tmo}, 32'h1);
        check("R10 irq on enabled timeout", {31'b0, irq}, 32'h1);
        check("R8 reset held at timeout", {31'b0, wreset}, 32'h0);
        ticks(1);
        check("R8 reset held after one tick", {31'b0, wreset}, 32'h0);
        ticks(1);
        check("R8 reset after two ticks", {31'b0, wreset}, 32'h1);
        repeat (20) @(negedge clk);
        wr_reg(A_EV_TMO, 32'h0);
        check("R11 flag clear by write", {31'b0, ev_tmo}, 32'h0);
        check("R9 reset survives flag clear", {31'b0, wreset}, 32'h1);
        keyed_stop();
        check("R9 stop withdraws delayed reset", {31'b0, wreset}, 32'h0);
        check("R10 stopped flag masked off", {31'b0, irq}, 32'h0);
        wr_reg(A_IEN_SET, 32'h2);
        check("R10 irq on enabled stopped flag", {31'b0, irq}, 32'h1);
        rd_reg(A_IEN_CLR, v); check("R10 mask read at clear address", v, 32'h3);
        wr_reg(A_IEN_CLR, 32'h2);
        check("R10 irq drops after mask clear", {31'b0, irq}, 32'h0);
        clear_flags();
    endtask

    task automatic t_cancel();
        wr_reg(A_START, 32'h1);
        ticks(16);
        check("R2 timeout before cancel", {31'b0, ev_tmo}, 32'h1);
        ticks(1);
        keyed_stop();
        ticks(3);
        check("R9 pending reset cancelled by stop", {31'b0, wreset}, 32'h0);
        wr_reg(A_IEN_CLR, 32'h3);
        clear_flags();
    endtask

    task automatic t_stop_disallowed();
        logic [31:0] v;
        wr_reg(A_CFG, 32'h01);
        wr_reg(A_START, 32'h1);
        keyed_stop();
        check("R7 stop refused without stop-allowed bit", {31'b0, running}, 32'h1);
        check("R7 no stopped flag when refused", {31'b0, ev_stp}, 32'h0);
        do_reset();
        check("R5 reset ends run", {31'b0, running}, 32'h0);
        rd_reg(A_RELOAD, v); check("R4 reload restored by reset", v, 32'hFFFF_FFFF);
        wr_reg(A_RELOAD, 32'd40);
        rd_reg(A_RELOAD, v); check("R5 reload writable after reset", v, 32'd40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_setup_regs();
        t_period();
        t_lock_and_keys();
        t_grant();
        t_pause();
        t_delay_irq();
        t_cancel();
        t_stop_disallowed();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule